// File: doc/BRIEF.md
# Serial Port Control and Status Register Bank

This block is the software-facing side of an asynchronous serial port. It holds eight byte-wide registers on a simple single-cycle bus and keeps the port's status flags. It turns line-side events into four interrupt outputs: receive-full, error, transmit-empty and transmit-end. It also passes the mode, bit-rate and control bytes to the shifter and baud-timing logic.

Line-side logic presents each received byte with a one-cycle strobe and reports a break condition with a second strobe. The transmit shifter receives a start pulse with the byte to send and answers with a done strobe when the shift completes. The bank decides whether a pending byte follows immediately or the port goes idle.

Top module: `uart_csr_bank`

Register offsets: 0 mode, 1 bit-rate, 2 control, 3 transmit data, 4 status, 5 receive data, 6 smart-card mode, 7 extended mode.

Control bits: [2] transmit-end interrupt enable, [4] receive enable, [5] transmit enable, [6] receive interrupt enable, [7] transmit interrupt enable.

Status bits: [0] multiprocessor transfer, [1] multiprocessor bit (always 0), [2] transmit end, [3] parity error, [4] framing error, [5] overrun, [6] receive full, [7] transmit empty.

## Requirements
- R1: After reset, offsets 0..7 read 0x00, 0xFF, 0x00, 0xFF, 0x84, 0x00, 0x00, 0x00. Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.
- R2: Writes to offset 0 (mode) and offset 1 (bit-rate) are ignored while control bit 5 or bit 4 is set. Otherwise they are stored.
- R3: A received byte that arrives while status bit 6 is clear is stored in offset 5 and sets status bit 6. If control bit 6 is set, it also gives a one-cycle `irq_rx_full` pulse.
- R4: Reading offset 5 clears status bit 6. A byte that arrives in the same cycle as that read is accepted, not treated as overrun.
- R5: A byte that arrives while status bit 6 is set is discarded and sets status bit 5. If control bit 6 is set, `irq_err` rises and stays high.
- R6: A break strobe sets status bit 4. If control bit 6 is set, it also raises `irq_err`.
- R7: A status write loads bit 0 from the written data. An error bit (3..5) clears only when it is written 0 and the most recent status read showed it set. Other status bits are unchanged. `irq_err` drops when that snapshot had any error bit set and the resulting error field is zero.
- R8: A control write with bit 6 clear drops `irq_err`. A control write with bit 2 clear drops `irq_tx_end`.
- R9: A control write with bit 5 set sets status bits 7 and 2. It pulses `irq_tx_empty` for one cycle if the written bit 7 is set.
- R10: A transmit-data write while status bit 2 is set pulses `tx_start` with the byte on `tx_data`, clears bit 2, keeps bit 7 set and pulses `irq_tx_empty` if control bit 7 is set. While bit 2 is clear, such a write clears bit 7 instead.
- R11: On `tx_done`, a pending byte (status bit 7 clear) is started as in R10. Otherwise status bit 2 is set and, if control bit 2 is set, `irq_tx_end` rises as a level.
- R12: Writes to offset 5 have no effect. Offsets 6 and 7 are plain storage. Offsets above 7 read 0xFF and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read |
| line_rx_valid | input | 1 | Received-byte strobe |
| line_rx_data | input | 8 | Received byte |
| line_break | input | 1 | Break-detect strobe |
| tx_done | input | 1 | Shifter finished a byte |
| tx_start | output | 1 | One-cycle pulse: load and send `tx_data` |
| tx_data | output | 8 | Transmit data register |
| cfg_mode | output | 8 | Mode register |
| cfg_rate | output | 8 | Bit-rate register |
| cfg_ctrl | output | 8 | Control register |
| irq_rx_full | output | 1 | Receive-full pulse |
| irq_err | output | 1 | Error level |
| irq_tx_empty | output | 1 | Transmit-empty pulse |
| irq_tx_end | output | 1 | Transmit-end level |

## Verification
Every output is registered, so each result is due exactly one cycle after the stimulus that caused it. Read data, flag changes, interrupt pulses and the transmit start pulse all land on the edge that samples the strobe or bus access. The bench drives on falling edges and inspects outputs on the next falling edge, which falls inside the cycle a pulse is alive. Expected read data goes into a queue when the read is issued, and a monitor pops it one cycle later. Cases that involve a read and a line event in the same cycle are driven as one combined access, so the ordering rule is checked directly.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

    localparam int DW   = 8;
    localparam int NREG = 8;
    localparam int SELW = $clog2(NREG);

    // register offsets
    localparam logic [SELW-1:0] OFS_MODE = 3'd0;
    localparam logic [SELW-1:0] OFS_RATE = 3'd1;
    localparam logic [SELW-1:0] OFS_CTRL = 3'd2;
    localparam logic [SELW-1:0] OFS_TXD  = 3'd3;
    localparam logic [SELW-1:0] OFS_STAT = 3'd4;
    localparam logic [SELW-1:0] OFS_RXD  = 3'd5;
    localparam logic [SELW-1:0] OFS_SCM  = 3'd6;
    localparam logic [SELW-1:0] OFS_EXT  = 3'd7;

    // control bit positions
    localparam int CTL_TEIE = 2;
    localparam int CTL_RE   = 4;
    localparam int CTL_TE   = 5;
    localparam int CTL_RIE  = 6;
    localparam int CTL_TIE  = 7;

    // status bit positions
    localparam int ST_MPBT = 0;
    localparam int ST_TEND = 2;
    localparam int ST_PER  = 3;
    localparam int ST_FER  = 4;
    localparam int ST_ORER = 5;
    localparam int ST_RDRF = 6;
    localparam int ST_TDRE = 7;

    // reset values
    localparam logic [DW-1:0] RST_MODE = 8'h00;
    localparam logic [DW-1:0] RST_RATE = 8'hFF;
    localparam logic [DW-1:0] RST_CTRL = 8'h00;
    localparam logic [DW-1:0] RST_TXD  = 8'hFF;
    localparam logic [DW-1:0] RST_STAT = 8'h84;
    localparam logic [DW-1:0] RST_RXD  = 8'h00;
    localparam logic [DW-1:0] RST_SCM  = 8'h00;
    localparam logic [DW-1:0] RST_EXT  = 8'h00;
    localparam logic [DW-1:0] MISS_VAL = 8'hFF;

    typedef struct packed {
        logic [DW-1:0] mode;
        logic [DW-1:0] rate;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] scm;
        logic [DW-1:0] ext;
    } cfg_regs_t;

    typedef struct packed {
        logic [DW-1:0] stat;
        logic [DW-1:0] snap;
        logic [DW-1:0] rxd;
        logic [DW-1:0] txd;
        logic          irq_err;
        logic          irq_tend;
        logic          irq_rx;
        logic          irq_txe;
        logic          tx_start;
    } stat_regs_t;

endpackage

// File: rtl/uart_csr_cfg.sv
module uart_csr_cfg
    import uart_csr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_mode,
    input  logic          wr_rate,
    input  logic          wr_ctrl,
    input  logic          wr_scm,
    input  logic          wr_ext,
    input  logic [DW-1:0] wdata,
    output cfg_regs_t     cfg
);

    cfg_regs_t cfg_d, cfg_q;
    logic      locked;

    always_comb begin
        cfg_d  = cfg_q;
        locked = cfg_q.ctrl[CTL_TE] | cfg_q.ctrl[CTL_RE];
        if (wr_mode && !locked) cfg_d.mode = wdata;
        if (wr_rate && !locked) cfg_d.rate = wdata;
        if (wr_ctrl)            cfg_d.ctrl = wdata;
        if (wr_scm)             cfg_d.scm  = wdata;
        if (wr_ext)             cfg_d.ext  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: RST_MODE, rate: RST_RATE, ctrl: RST_CTRL,
                       scm: RST_SCM, ext: RST_EXT};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/uart_csr_status.sv
module uart_csr_status
    import uart_csr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic          wr_txd,
    input  logic          wr_stat,
    input  logic          rd_stat,
    input  logic          rd_rxd,
    input  logic [DW-1:0] wdata,
    input  logic          en_rie,
    input  logic          en_tie,
    input  logic          en_teie,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          brk,
    input  logic          tx_done,
    output logic [DW-1:0] stat,
    output logic [DW-1:0] rxd,
    output logic [DW-1:0] txd,
    output logic          irq_err,
    output logic          irq_tend,
    output logic          irq_rx,
    output logic          irq_txe,
    output logic          tx_start
);

    stat_regs_t st_d, st_q;
    logic       send;

    always_comb begin
        st_d          = st_q;
        st_d.irq_rx   = 1'b0;
        st_d.irq_txe  = 1'b0;
        st_d.tx_start = 1'b0;
        send          = 1'b0;

        // control write side effects use the written value
        if (wr_ctrl) begin
            if (wdata[CTL_TE]) begin
                st_d.stat[ST_TDRE] = 1'b1;
                st_d.stat[ST_TEND] = 1'b1;
                if (wdata[CTL_TIE]) st_d.irq_txe = 1'b1;
            end
            if (!wdata[CTL_TEIE]) st_d.irq_tend = 1'b0;
            if (!wdata[CTL_RIE])  st_d.irq_err  = 1'b0;
        end

        // transmit data write
        if (wr_txd) begin
            st_d.txd = wdata;
            if (st_q.stat[ST_TEND]) send = 1'b1;
            else                    st_d.stat[ST_TDRE] = 1'b0;
        end

        // shifter finished
        if (tx_done) begin
            if (!st_d.stat[ST_TDRE]) begin
                send = 1'b1;
            end else begin
                st_d.stat[ST_TEND] = 1'b1;
                if (en_teie) st_d.irq_tend = 1'b1;
            end
        end

        if (send) begin
            st_d.tx_start      = 1'b1;
            st_d.stat[ST_TEND] = 1'b0;
            st_d.stat[ST_TDRE] = 1'b1;
            st_d.irq_tend      = 1'b0;
            if (en_tie) st_d.irq_txe = 1'b1;
        end

        // status read snapshot
        if (rd_stat) st_d.snap = st_q.stat;

        // status write: transfer bit and read-then-write-zero error clear
        if (wr_stat) begin
            st_d.stat[ST_MPBT] = wdata[ST_MPBT];
            for (int k = ST_PER; k <= ST_ORER; k++) begin
                if (!wdata[k] && st_q.snap[k]) st_d.stat[k] = 1'b0;
            end
            if ((|st_q.snap[ST_ORER:ST_PER]) && (st_d.stat[ST_ORER:ST_PER] == '0))
                st_d.irq_err = 1'b0;
        end

        // receive data read frees the holding register first
        if (rd_rxd) st_d.stat[ST_RDRF] = 1'b0;

        // line events come last so they win over same-cycle writes
        if (rx_valid) begin
            if (st_d.stat[ST_RDRF]) begin
                st_d.stat[ST_ORER] = 1'b1;
                if (en_rie) st_d.irq_err = 1'b1;
            end else begin
                st_d.rxd           = rx_byte;
                st_d.stat[ST_RDRF] = 1'b1;
                st_d.irq_rx        = en_rie;
            end
        end

        if (brk) begin
            st_d.stat[ST_FER] = 1'b1;
            if (en_rie) st_d.irq_err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stat: RST_STAT, snap: RST_STAT, rxd: RST_RXD, txd: RST_TXD,
                      irq_err: 1'b0, irq_tend: 1'b0, irq_rx: 1'b0,
                      irq_txe: 1'b0, tx_start: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign stat     = st_q.stat;
    assign rxd      = st_q.rxd;
    assign txd      = st_q.txd;
    assign irq_err  = st_q.irq_err;
    assign irq_tend = st_q.irq_tend;
    assign irq_rx   = st_q.irq_rx;
    assign irq_txe  = st_q.irq_txe;
    assign tx_start = st_q.tx_start;

endmodule

// File: rtl/uart_csr_rdmux.sv
module uart_csr_rdmux
    import uart_csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic            hit,
    input  logic [SELW-1:0] sel,
    input  cfg_regs_t       cfg,
    input  logic [DW-1:0]   stat,
    input  logic [DW-1:0]   rxd,
    input  logic [DW-1:0]   txd,
    output logic [DW-1:0]   rdata
);

    logic [DW-1:0] rdata_d, rdata_q;
    logic [DW-1:0] sel_val;

    always_comb begin
        unique case (sel)
            OFS_MODE: sel_val = cfg.mode;
            OFS_RATE: sel_val = cfg.rate;
            OFS_CTRL: sel_val = cfg.ctrl;
            OFS_TXD:  sel_val = txd;
            OFS_STAT: sel_val = stat;
            OFS_RXD:  sel_val = rxd;
            OFS_SCM:  sel_val = cfg.scm;
            default:  sel_val = cfg.ext;
        endcase
        rdata_d = rdata_q;
        if (rd_en) rdata_d = hit ? sel_val : MISS_VAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/uart_csr_bank.sv
module uart_csr_bank
    import uart_csr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              line_rx_valid,
    input  logic [7:0]        line_rx_data,
    input  logic              line_break,
    input  logic              tx_done,
    output logic              tx_start,
    output logic [7:0]        tx_data,
    output logic [7:0]        cfg_mode,
    output logic [7:0]        cfg_rate,
    output logic [7:0]        cfg_ctrl,
    output logic              irq_rx_full,
    output logic              irq_err,
    output logic              irq_tx_empty,
    output logic              irq_tx_end
);

    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NREG);

    logic            hit;
    logic [SELW-1:0] sel;
    logic            wr_hit, rd_hit;
    cfg_regs_t       cfg_w;
    logic [DW-1:0]   stat_w, rxd_w;

    assign hit    = bus_addr < LIMIT;
    assign sel    = bus_addr[SELW-1:0];
    assign wr_hit = bus_wr & hit;
    assign rd_hit = bus_rd & hit;

    uart_csr_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mode (wr_hit && sel == OFS_MODE),
        .wr_rate (wr_hit && sel == OFS_RATE),
        .wr_ctrl (wr_hit && sel == OFS_CTRL),
        .wr_scm  (wr_hit && sel == OFS_SCM),
        .wr_ext  (wr_hit && sel == OFS_EXT),
        .wdata   (bus_wdata),
        .cfg     (cfg_w)
    );

    uart_csr_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_hit && sel == OFS_CTRL),
        .wr_txd   (wr_hit && sel == OFS_TXD),
        .wr_stat  (wr_hit && sel == OFS_STAT),
        .rd_stat  (rd_hit && sel == OFS_STAT),
        .rd_rxd   (rd_hit && sel == OFS_RXD),
        .wdata    (bus_wdata),
        .en_rie   (cfg_w.ctrl[CTL_RIE]),
        .en_tie   (cfg_w.ctrl[CTL_TIE]),
        .en_teie  (cfg_w.ctrl[CTL_TEIE]),
        .rx_valid (line_rx_valid),
        .rx_byte  (line_rx_data),
        .brk      (line_break),
        .tx_done  (tx_done),
        .stat     (stat_w),
        .rxd      (rxd_w),
        .txd      (tx_data),
        .irq_err  (irq_err),
        .irq_tend (irq_tx_end),
        .irq_rx   (irq_rx_full),
        .irq_txe  (irq_tx_empty),
        .tx_start (tx_start)
    );

    uart_csr_rdmux u_rdmux (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (bus_rd),
        .hit   (hit),
        .sel   (sel),
        .cfg   (cfg_w),
        .stat  (stat_w),
        .rxd   (rxd_w),
        .txd   (tx_data),
        .rdata (bus_rdata)
    );

    assign cfg_mode = cfg_w.mode;
    assign cfg_rate = cfg_w.rate;
    assign cfg_ctrl = cfg_w.ctrl;

endmodule

// File: rtl/uart_csr_bank_chk.sv
module uart_csr_bank_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              line_rx_valid,
    input logic              line_break,
    input logic [7:0]        cfg_mode,
    input logic [7:0]        cfg_ctrl,
    input logic [7:0]        stat,
    input logic [7:0]        rxd,
    input logic              irq_rx_full,
    input logic              irq_err,
    input logic              irq_tx_end,
    input logic              tx_start
);

    p_mode_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0) && (cfg_ctrl[5] || cfg_ctrl[4])) |=> $stable(cfg_mode));

    p_rx_pulse_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_full |-> stat[6]);

    p_read_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(5) && !line_rx_valid) |=> !stat[6]);

    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_rx_valid && stat[6] && !(bus_rd && bus_addr == ADDR_W'(5))) |=> stat[5]);

    p_err_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_err) |-> (|stat[5:3]));

    p_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_break |=> stat[4]);

    p_start_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (stat[7] && !stat[2]));

    p_tend_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_end |-> stat[2]);

    p_rxd_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(5) && !line_rx_valid) |=> $stable(rxd));

endmodule

bind uart_csr_bank uart_csr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .line_rx_valid (line_rx_valid),
    .line_break    (line_break),
    .cfg_mode      (cfg_mode),
    .cfg_ctrl      (cfg_ctrl),
    .stat          (stat_w),
    .rxd           (rxd_w),
    .irq_rx_full   (irq_rx_full),
    .irq_err       (irq_err),
    .irq_tx_end    (irq_tx_end),
    .tx_start      (tx_start)
);

// File: tb/uart_csr_bank_bench.sv
module uart_csr_bank_bench;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          line_rx_valid = 1'b0;
    logic [7:0]    line_rx_data = '0;
    logic          line_break = 1'b0;
    logic          tx_done = 1'b0;
    logic          tx_start;
    logic [7:0]    tx_data, cfg_mode, cfg_rate, cfg_ctrl;
    logic          irq_rx_full, irq_err, irq_tx_empty, irq_tx_end;

    int   n_cmp = 0;
    int   n_bad = 0;
    logic rd_d = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    uart_csr_bank #(.ADDR_W(AW)) u_uart_csr_bank (.*);

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: read data is due one cycle after the read strobe
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) check("queue R1", 8'h01, 8'h00);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic rx(input logic [7:0] b);
        @(negedge clk); line_rx_valid = 1'b1; line_rx_data = b;
        @(negedge clk); line_rx_valid = 1'b0;
    endtask

    task automatic brk();
        @(negedge clk); line_break = 1'b1;
        @(negedge clk); line_break = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(0, 8'h00, "R1 mode");   rd(1, 8'hFF, "R1 rate");
        rd(2, 8'h00, "R1 ctrl");   rd(3, 8'hFF, "R1 txd");
        rd(4, 8'h84, "R1 stat");   rd(5, 8'h00, "R1 rxd");
        rd(6, 8'h00, "R1 scm");    rd(7, 8'h00, "R1 ext");
        check("R1 irq idle", {irq_rx_full, irq_err, irq_tx_empty, irq_tx_end}, 8'h00);

        // R2 unlocked writes, R12 storage and out-of-range
        wr(0, 8'h35); wr(1, 8'h1A);
        rd(0, 8'h35, "R2 mode stored"); rd(1, 8'h1A, "R2 rate stored");
        wr(6, 8'h5A); wr(7, 8'h11);
        rd(6, 8'h5A, "R12 scm"); rd(7, 8'h11, "R12 ext");
        wr(9, 8'h77); rd(9, 8'hFF, "R12 miss");

        // enable RIE, TE, RE, TEIE; no TIE so no pulse
        wr(2, 8'h74);
        check("R9 no txe pulse", {7'd0, irq_tx_empty}, 8'h00);
        wr(0, 8'h00); wr(1, 8'h00);
        rd(0, 8'h35, "R2 mode locked"); rd(1, 8'h1A, "R2 rate locked");
        check("R2 cfg_mode port", cfg_mode, 8'h35);

        // R3 receive
        rx(8'hA5);
        check("R3 rx pulse", {7'd0, irq_rx_full}, 8'h01);
        @(negedge clk);
        check("R3 pulse one cycle", {7'd0, irq_rx_full}, 8'h00);
        rd(4, 8'hC4, "R3 stat full");
        rd(5, 8'hA5, "R3 rxd");
        rd(4, 8'h84, "R4 read clears");

        // R5 overrun
        rx(8'h11); rx(8'h22);
        check("R5 err irq", {7'd0, irq_err}, 8'h01);
        rd(5, 8'h11, "R5 byte kept");
        rd(4, 8'hA4, "R5 overrun flag");
        wr(4, 8'h00);
        check("R7 err irq drop", {7'd0, irq_err}, 8'h00);
        rd(4, 8'h84, "R7 overrun cleared");

        // R6 break and R7 read-before-clear
        brk();
        check("R6 err irq", {7'd0, irq_err}, 8'h01);
        wr(4, 8'h00);
        check("R7 no clear without read", {7'd0, irq_err}, 8'h01);
        rd(4, 8'h94, "R7 fer kept");
        wr(4, 8'h01);
        check("R7 irq after clear", {7'd0, irq_err}, 8'h00);
        rd(4, 8'h85, "R7 mpbt set fer clear");
        wr(4, 8'h00);

        // R8 control write drops error irq
        brk();
        check("R6 err irq again", {7'd0, irq_err}, 8'h01);
        wr(2, 8'h34);
        check("R8 rie off drops err", {7'd0, irq_err}, 8'h00);
        rd(4, 8'h94, "R6 fer set"); wr(4, 8'h00);

        // R3 no pulse without RIE; R4 same-cycle read and arrival
        rx(8'h33);
        check("R3 no pulse rie off", {7'd0, irq_rx_full}, 8'h00);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 5; line_rx_valid = 1'b1; line_rx_data = 8'h44;
        exp_q.push_back(8'h33); tag_q.push_back("R4 same-cycle read");
        @(negedge clk);
        bus_rd = 1'b0; line_rx_valid = 1'b0;
        rd(4, 8'hC4, "R4 accepted no overrun");
        rd(5, 8'h44, "R4 new byte");

        // R9 transmit enable with TIE
        wr(2, 8'hB4);
        check("R9 txe pulse", {7'd0, irq_tx_empty}, 8'h01);

        // R10 immediate send when idle
        wr(3, 8'h5C);
        check("R10 start", {7'd0, tx_start}, 8'h01);
        check("R10 byte", tx_data, 8'h5C);
        check("R10 txe pulse", {7'd0, irq_tx_empty}, 8'h01);
        rd(4, 8'h80, "R10 tend clear");
        wr(3, 8'h6D);
        check("R10 no start busy", {7'd0, tx_start}, 8'h00);
        rd(4, 8'h00, "R10 tdre clear");

        // R11 done with pending, then done when empty
        done_pulse();
        check("R11 chained start", {7'd0, tx_start}, 8'h01);
        check("R11 chained byte", tx_data, 8'h6D);
        rd(4, 8'h80, "R11 pending sent");
        done_pulse();
        check("R11 tend irq", {7'd0, irq_tx_end}, 8'h01);
        check("R11 no start", {7'd0, tx_start}, 8'h00);
        rd(4, 8'h84, "R11 tend set");
        wr(2, 8'hB0);
        check("R8 teie off drops tend", {7'd0, irq_tx_end}, 8'h00);

        // R12 receive data write ignored
        wr(5, 8'h99);
        rd(5, 8'h44, "R12 rxd unchanged");
        rd(3, 8'h6D, "R10 txd readback");

        // R2 unlocked again
        wr(2, 8'h00); wr(0, 8'h01); wr(1, 8'h80);
        rd(0, 8'h01, "R2 mode after unlock");
        rd(1, 8'h80, "R2 rate after unlock");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R1 queue drained", 8'(exp_q.size()), 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule